// File: doc/BRIEF.md
# Frequency Synthesizer Divider and Phase/Frequency Detector

This block is the digital heart of a crystal-referenced frequency synthesizer. A loadable down-counter divides the prescaled oscillator clock by a programmable ratio N. A second counter divides the crystal clock by a fixed ratio to form the comparison reference. A phase/frequency detector watches the falling edges of both divided signals. It drives lead and lag pulses toward an external charge pump and flags when the pump output should float.

Both input clocks arrive as single-cycle tick enables in one fast clock domain. Control bits from a register block can float the pump, route the two divided signals onto two port pins for test, and pass a current-select bit and an amplifier-disable bit through unchanged. A lock indicator reports phase agreement that has held over several reference periods.

Top module: `synth_pfd_core`

## Requirements
- R1: While reset is held and at release, `pump_up`, `pump_dn` and `locked` are 0 and `pump_hiz` is 1.
- R2: `cy_out` falls once every N `vco_tick` pulses, at the terminal count of the divider.
- R3: `ref_out` falls once every REF_DIV (default 512) `xtal_tick` pulses.
- R4: When the divided oscillator falls before the reference, `pump_up` is high for the phase difference in fast-clock cycles and `pump_dn` stays low.
- R5: When the reference falls before the divided oscillator, `pump_dn` is high for the phase difference and `pump_up` stays low.
- R6: `pump_up` and `pump_dn` are never high together, and `pump_hiz` is 1 whenever neither is high. Coincident falling edges produce no pulse on either pin.
- R7: With `tri_force` = 1, `pump_up` and `pump_dn` stay 0 and `pump_hiz` stays 1.
- R8: With `test_route` = 1, `p6_out` follows `ref_out` and `p7_out` follows `cy_out`. With `test_route` = 0, they follow `port_p6` and `port_p7`.
- R9: `cur_hi` equals `cur_sel` and `amp_dis` equals `amp_off` in every cycle.
- R10: An `n_word` below N_MIN (default 256) divides by N_MIN.
- R11: A new `n_word` is applied only at the next terminal count, so the period in progress keeps the old length.
- R12: `locked` rises after LOCK_CYC (default 4) consecutive reference falling edges that coincide with an oscillator falling edge, with no one-sided pulse in between. Any mismatching reference period clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_tick | input | 1 | One pulse per prescaled oscillator period |
| xtal_tick | input | 1 | One pulse per crystal period |
| n_word | input | NW | Requested division ratio |
| tri_force | input | 1 | Float the pump output |
| test_route | input | 1 | Route divided signals to port pins |
| cur_sel | input | 1 | Pump current select |
| amp_off | input | 1 | Tuning amplifier disable |
| port_p6 | input | 1 | Register value for port 6 |
| port_p7 | input | 1 | Register value for port 7 |
| pump_up | output | 1 | Source-current request |
| pump_dn | output | 1 | Sink-current request |
| pump_hiz | output | 1 | Pump output floats |
| cur_hi | output | 1 | Pump current select, passed through |
| amp_dis | output | 1 | Amplifier disable, passed through |
| cy_out | output | 1 | Divided oscillator signal |
| ref_out | output | 1 | Divided reference signal |
| p6_out | output | 1 | Port 6 pin value |
| p7_out | output | 1 | Port 7 pin value |
| locked | output | 1 | Phase lock indicator |

## Verification
The assertions assume that `vco_tick` and `xtal_tick` are single-cycle enables sampled on `clk`. They also assume that a detector event landing in one of the few reset-delay cycles may be dropped. The stimulus keeps both ticks high on every cycle and uses ratios that are multiples of 256. Every divided falling edge therefore lands on a predictable cycle and never inside the reset-delay window. The bench resets before each ratio, so each pattern starts with both dividers aligned at their first terminal count.

// File: rtl/synth_pfd_core.sv
module synth_pfd_core #(
  parameter int NW       = 15,
  parameter int N_MIN    = 256,
  parameter int REF_DIV  = 512,
  parameter int LOCK_CYC = 4,
  parameter int RST_DLY  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vco_tick,
  input  logic          xtal_tick,
  input  logic [NW-1:0] n_word,
  input  logic          tri_force,
  input  logic          test_route,
  input  logic          cur_sel,
  input  logic          amp_off,
  input  logic          port_p6,
  input  logic          port_p7,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          pump_hiz,
  output logic          cur_hi,
  output logic          amp_dis,
  output logic          cy_out,
  output logic          ref_out,
  output logic          p6_out,
  output logic          p7_out,
  output logic          locked
);
  localparam int RW = $clog2(REF_DIV);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam int DW = $clog2(RST_DLY + 1);

  logic [NW-1:0] cnt, n_act, n_load;
  logic [RW-1:0] rcnt;
  logic          up, dn, clr, mis;
  logic [DW-1:0] rc;
  logic [LW-1:0] lk;
  logic          vfall, rfall;

  assign n_load = (n_word < NW'(N_MIN)) ? NW'(N_MIN) : n_word;
  assign vfall  = vco_tick && (cnt == '0);
  assign rfall  = xtal_tick && (rcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      n_act <= NW'(N_MIN);
    end else if (vco_tick) begin
      if (cnt == '0) begin
        n_act <= n_load;
        cnt   <= n_load - 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rcnt <= '0;
    else if (xtal_tick)
      rcnt <= (rcnt == '0) ? RW'(REF_DIV - 1) : rcnt - 1'b1;
  end

  assign cy_out  = cnt < (n_act >> 1);
  assign ref_out = rcnt < RW'(REF_DIV / 2);

  assign clr = up && dn && (rc == DW'(RST_DLY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
      rc <= '0;
    end else begin
      up <= clr ? 1'b0 : (up | vfall);
      dn <= clr ? 1'b0 : (dn | rfall);
      rc <= (up && dn && !clr) ? rc + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk  <= '0;
      mis <= 1'b0;
    end else if (rfall) begin
      mis <= 1'b0;
      if (vfall && !mis && !(up ^ dn)) begin
        if (lk != LW'(LOCK_CYC)) lk <= lk + 1'b1;
      end else begin
        lk <= '0;
      end
    end else if (up ^ dn) begin
      mis <= 1'b1;
    end
  end

  assign locked   = (lk == LW'(LOCK_CYC));
  assign pump_up  = up && !dn && !tri_force;
  assign pump_dn  = dn && !up && !tri_force;
  assign pump_hiz = tri_force || !(up ^ dn);
  assign cur_hi   = cur_sel;
  assign amp_dis  = amp_off;
  assign p6_out   = test_route ? ref_out : port_p6;
  assign p7_out   = test_route ? cy_out  : port_p7;

  a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));
  a_r6_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_up && !pump_dn) |-> pump_hiz);
  a_r7_tri: assert property (@(posedge clk) disable iff (!rst_n)
    tri_force |-> (pump_hiz && !pump_up && !pump_dn));
  a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
    n_act >= NW'(N_MIN));
  a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(vfall)) |-> (cnt == n_act - 1'b1));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(vfall)) |-> $stable(n_act));
  a_r12_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(xtal_tick));
  a_r4_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rc < DW'(RST_DLY));
endmodule

// File: tb/sim_synth_pfd_core.sv
module sim_synth_pfd_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vco_tick = 1'b1, xtal_tick = 1'b1;
  logic [14:0] n_word = 15'd512;
  logic tri_force = 1'b0, test_route = 1'b0, cur_sel = 1'b0, amp_off = 1'b0;
  logic port_p6 = 1'b0, port_p7 = 1'b0;
  logic pump_up, pump_dn, pump_hiz, cur_hi, amp_dis, cy_out, ref_out, p6_out, p7_out, locked;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_pfd_core u0 (.*);

  localparam int NROW = 5;
  localparam int VN  [NROW] = '{512, 256, 1024, 100, 2048};
  localparam int VUP [NROW] = '{0, 1024, 0, 1024, 0};
  localparam int VDN [NROW] = '{0, 0, 1024, 0, 1536};
  localparam int VLK [NROW] = '{1, 0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_pulses(input int len, output int nu, output int nd, output int nh);
    nu = 0; nd = 0; nh = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pump_up) nu++;
      if (pump_dn) nd++;
      if (!pump_hiz) nh++;
    end
  endtask

  task automatic wait_cy_fall(output int cyc);
    logic p;
    cyc = 0;
    do begin
      p = cy_out;
      @(negedge clk);
      cyc++;
    end while (!(p && !cy_out) && cyc < 10000);
  endtask

  task automatic wait_ref_fall(output int cyc);
    logic p;
    cyc = 0;
    do begin
      p = ref_out;
      @(negedge clk);
      cyc++;
    end while (!(p && !ref_out) && cyc < 10000);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nu, nd, nh, c, mm;
    // R1 reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pump_up && !pump_dn && pump_hiz && !locked, "R1", {pump_up, pump_dn, pump_hiz, locked}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!locked, "R1", locked, 0);

    // vector table: R4 R5 R6 R10 R12
    for (int r = 0; r < NROW; r++) begin
      n_word = 15'(VN[r]);
      do_reset();
      repeat (2048) @(negedge clk);
      count_pulses(2048, nu, nd, nh);
      chk(nu == VUP[r], "R4 up width", nu, VUP[r]);
      chk(nd == VDN[r], "R5 dn width", nd, VDN[r]);
      chk(nh == nu + nd, "R6 hiz", nh, nu + nd);
      chk(locked == VLK[r], "R12 lock", locked, VLK[r]);
    end

    // R12 lock timing and loss
    n_word = 15'd512;
    do_reset();
    repeat (1000) @(negedge clk);
    chk(!locked, "R12 early", locked, 0);
    repeat (1000) @(negedge clk);
    chk(locked, "R12 set", locked, 1);
    n_word = 15'd256;
    repeat (1100) @(negedge clk);
    chk(!locked, "R12 cleared", locked, 0);

    // R2 / R3 periods
    n_word = 15'd300;
    do_reset();
    wait_cy_fall(c);
    wait_cy_fall(c);
    chk(c == 300, "R2 period", c, 300);
    wait_ref_fall(c);
    wait_ref_fall(c);
    chk(c == 512, "R3 period", c, 512);

    // R11 deferred load
    wait_cy_fall(c);
    repeat (10) @(negedge clk);
    n_word = 15'd400;
    wait_cy_fall(c);
    chk(c + 10 == 300, "R11 old period", c + 10, 300);
    wait_cy_fall(c);
    chk(c == 400, "R11 new period", c, 400);

    // R10 clamp period
    n_word = 15'd5;
    do_reset();
    wait_cy_fall(c);
    wait_cy_fall(c);
    chk(c == 256, "R10 clamp period", c, 256);

    // R7 forced float
    n_word = 15'd256;
    tri_force = 1'b1;
    do_reset();
    count_pulses(2048, nu, nd, nh);
    chk(nu == 0 && nd == 0 && nh == 0, "R7 tri", nu + nd + nh, 0);
    tri_force = 1'b0;
    count_pulses(2048, nu, nd, nh);
    chk(nu == 1024, "R7 release", nu, 1024);

    // R8 test routing
    test_route = 1'b1;
    port_p6 = 1'b0; port_p7 = 1'b0;
    mm = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (p6_out !== ref_out || p7_out !== cy_out) mm++;
    end
    chk(mm == 0, "R8 routed", mm, 0);
    test_route = 1'b0;
    port_p6 = 1'b1; port_p7 = 1'b0;
    mm = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (p6_out !== 1'b1 || p7_out !== 1'b0) mm++;
    end
    chk(mm == 0, "R8 register a", mm, 0);
    port_p6 = 1'b0; port_p7 = 1'b1;
    @(negedge clk);
    chk(p6_out == 1'b0 && p7_out == 1'b1, "R8 register b", {p6_out, p7_out}, 2'b01);

    // R9 pass-through
    cur_sel = 1'b1; amp_off = 1'b0;
    @(negedge clk);
    chk(cur_hi == 1'b1 && amp_dis == 1'b0, "R9 a", {cur_hi, amp_dis}, 2'b10);
    cur_sel = 1'b0; amp_off = 1'b1;
    @(negedge clk);
    chk(cur_hi == 1'b0 && amp_dis == 1'b1, "R9 b", {cur_hi, amp_dis}, 2'b01);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule